// File: doc/BRIEF.md
# Chip reset sequencer with watchdog

This block owns the chip reset. A one-shot delay counter holds `chip_rst` asserted for a fixed number of timebase ticks after any trigger. The triggers are power becoming good, a level stop-recovery request, and a watchdog expiry. A watchdog expiry adds a short tail of plain clock cycles to the hold time. The block also records which trigger acted last. It drives a constant restart address that the core fetches from once reset drops.

The watchdog is a retriggerable up-counter. The decoded watchdog command arms it the first time and clears it on every later use. A separate halt-enable command lets it keep counting during HALT without clearing it. Two straps set the policy. The permanent strap enables the watchdog straight out of reset and lets it count through reset itself. The clock-source strap picks the timebase for both counters: every `clk` cycle (system clock), or only the cycles that carry the `rc_tick` enable (slow oscillator). Both clocks arrive as plain inputs, so the block stays in one clock domain.

Sequencer states: `SQ_DELAY` (counting hold ticks), `SQ_EXTRA` (counting the clock tail after a watchdog expiry) and `SQ_RUN` (reset released). Its transitions are:
- `DELAY->EXTRA` at the end of the count when the cause was the watchdog.
- `DELAY->RUN` at the end of the count for any other cause.
- `EXTRA->RUN` at the end of the tail.
- Any state to `DELAY` on a trigger.
- Any state to `DELAY` asynchronously while power is bad.

Watchdog states: `WD_IDLE` (not armed), `WD_ARMED` and `WD_ARMED_HALT`. Its transitions are:
- `IDLE->ARMED` on the first command outside reset.
- `ARMED->ARMED_HALT` on the halt-enable command.
- Any state to `IDLE` while reset is held.

Top module: `rstseq_top`

## Requirements
- R1: While `pwr_good` is low, `chip_rst` is 1 and `rst_cause` is 1 (power). After `pwr_good` rises, `chip_rst` stays 1 for exactly POR_TICKS timebase ticks, with no clock tail.
- R2: `rst_vector` always reads 16'h000C.
- R3: Without the permanent strap, the watchdog is not armed after any reset, and commands that arrive while `chip_rst` is 1 are ignored. The first `wdt_cmd` pulse outside reset arms it with a count of zero.
- R4: An armed watchdog that is not refreshed expires WDT_LIMIT ticks after arming or after the last refresh. The expiry asserts `chip_rst` with `rst_cause` set to 3 in RUN, 4 in HALT or 5 in STOP.
- R5: A `wdt_cmd` pulse to an enabled watchdog outside reset clears its count to zero.
- R6: A reset caused by the watchdog lasts POR_TICKS ticks plus EXTRA_CLKS clock cycles.
- R7: In HALT, the count freezes at its value unless halt-enable (`wdh_cmd`) was given after arming. Halt-enable does not clear the count. Halt-enable given before arming has no effect.
- R8: Without the permanent strap, the watchdog never expires in STOP mode.
- R9: With the permanent strap, the watchdog counts from power-up (also during reset) and runs in RUN and HALT. In STOP it runs only when the slow-oscillator timebase is selected.
- R10: `stop_rec_req` is a level. Each cycle it is 1, the next `chip_rst` is 1 and the hold count restarts with `rst_cause` 2. Release comes POR_TICKS ticks after its last high cycle, with no clock tail. If it coincides with a watchdog expiry, the watchdog cause wins.
- R11: With `opt_sysclk_src`=1 every clock is a tick. With 0 only cycles with `rc_tick`=1 are ticks, for both the hold count and the watchdog. The clock tail counts clocks.
- R12: `rst_cause` changes only in cycles where `chip_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_good | input | 1 | Supply good level; low acts as asynchronous reset |
| rc_tick | input | 1 | One-cycle enable marking slow-oscillator ticks |
| opt_perm | input | 1 | Strap: watchdog permanently enabled |
| opt_sysclk_src | input | 1 | Strap: 1 selects system clock as timebase, 0 the slow oscillator |
| stop_rec_req | input | 1 | Stop-mode recovery request (level) |
| wdt_cmd | input | 1 | Decoded watchdog arm/refresh strobe |
| wdh_cmd | input | 1 | Decoded halt-enable strobe |
| halt_mode | input | 1 | Core is in HALT |
| stop_mode | input | 1 | Core is in STOP |
| chip_rst | output | 1 | Chip reset, active high |
| rst_cause | output | 3 | Last trigger: 1 power, 2 stop recovery, 3/4/5 watchdog in RUN/HALT/STOP |
| rst_vector | output | 16 | Restart fetch address |

## Verification
The bench builds the block with WDT_LIMIT=40, POR_TICKS=12 and EXTRA_CLKS=3 instead of the full-size counts of 130416, 16362 and 18. This brings dozens of expiries, refreshes and hold windows into a few thousand cycles. The limit is kept well above the hold count, so a permanent-mode expiry measured from power-up lands after release and its cycle can be predicted exactly. Driving `rc_tick` by hand in the slow-oscillator case shows both counters freezing when ticks stop.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        CS_POWER   = 3'd1,
        CS_STOPREC = 3'd2,
        CS_WD_RUN  = 3'd3,
        CS_WD_HALT = 3'd4,
        CS_WD_STOP = 3'd5
    } cause_t;

    typedef enum logic [1:0] {
        SQ_DELAY = 2'd0,
        SQ_EXTRA = 2'd1,
        SQ_RUN   = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        WD_IDLE       = 2'd0,
        WD_ARMED      = 2'd1,
        WD_ARMED_HALT = 2'd2
    } wd_state_t;

endpackage

// File: rtl/rstseq_tick_sel.sv
module rstseq_tick_sel (
    input  logic sysclk_src,
    input  logic rc_tick,
    output logic tick
);
    // System clock source: every cycle is a tick; otherwise use the enable.
    always_comb begin
        tick = sysclk_src ? 1'b1 : rc_tick;
    end
endmodule

// File: rtl/rstseq_wdog.sv
module rstseq_wdog #(
    parameter int unsigned LIMIT = 130416,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          tick,
    input  logic          rst_hold,
    input  logic          wdt_cmd,
    input  logic          wdh_cmd,
    input  logic          halt_mode,
    input  logic          stop_mode,
    input  logic          opt_perm,
    input  logic          opt_sysclk_src,
    output logic          expire,
    output logic          halt_run,
    output logic [CW-1:0] cnt_q
);
    import rstseq_pkg::*;

    wd_state_t     state_q, state_d;
    logic [CW-1:0] cnt_d;
    logic          enabled, running, count_en, refresh;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= WD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE:       if (wdt_cmd) state_d = WD_ARMED;
            WD_ARMED:      if (wdh_cmd) state_d = WD_ARMED_HALT;
            WD_ARMED_HALT: state_d = WD_ARMED_HALT;
            default:       state_d = WD_IDLE;
        endcase
        if (rst_hold) state_d = WD_IDLE;
    end

    // Outputs and counter
    always_comb begin
        enabled  = opt_perm || (state_q != WD_IDLE);
        halt_run = opt_perm || (state_q == WD_ARMED_HALT);
        if (stop_mode)      running = opt_perm && !opt_sysclk_src;
        else if (halt_mode) running = halt_run;
        else                running = enabled;
        count_en = running && tick;
        expire   = count_en && (cnt_q == CW'(LIMIT - 1));
        refresh  = !rst_hold && wdt_cmd && enabled;
        if (rst_hold && !opt_perm)   cnt_d = '0;
        else if (refresh || expire)  cnt_d = '0;
        else if (count_en)           cnt_d = cnt_q + 1'b1;
        else                         cnt_d = cnt_q;
    end
endmodule

// File: rtl/rstseq_seq.sv
module rstseq_seq #(
    parameter int unsigned POR_TICKS  = 16362,
    parameter int unsigned EXTRA_CLKS = 18,
    localparam int unsigned DMAX      = (POR_TICKS > EXTRA_CLKS) ? POR_TICKS : EXTRA_CLKS,
    localparam int unsigned DW        = $clog2(DMAX + 1)
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                tick,
    input  logic                stop_req,
    input  logic                wd_expire,
    input  logic                halt_mode,
    input  logic                stop_mode,
    output logic                chip_rst,
    output rstseq_pkg::cause_t  cause
);
    import rstseq_pkg::*;

    seq_state_t    state_q, state_d;
    logic [DW-1:0] cnt_q, cnt_d;
    logic          tail_q, tail_d;
    cause_t        cause_q, cause_d;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= SQ_DELAY;
            cnt_q   <= '0;
            tail_q  <= 1'b0;
            cause_q <= CS_POWER;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tail_q  <= tail_d;
            cause_q <= cause_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        tail_d  = tail_q;
        cause_d = cause_q;
        unique case (state_q)
            SQ_DELAY: begin
                if (tick) begin
                    if (cnt_q == DW'(POR_TICKS - 1)) begin
                        cnt_d   = '0;
                        state_d = tail_q ? SQ_EXTRA : SQ_RUN;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            SQ_EXTRA: begin
                if (cnt_q == DW'(EXTRA_CLKS - 1)) begin
                    cnt_d   = '0;
                    state_d = SQ_RUN;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SQ_RUN:  state_d = SQ_RUN;
            default: state_d = SQ_DELAY;
        endcase
        // Triggers restart the hold from any state, including during reset.
        if (wd_expire) begin
            state_d = SQ_DELAY;
            cnt_d   = '0;
            tail_d  = 1'b1;
            if (stop_mode)      cause_d = CS_WD_STOP;
            else if (halt_mode) cause_d = CS_WD_HALT;
            else                cause_d = CS_WD_RUN;
        end else if (stop_req) begin
            state_d = SQ_DELAY;
            cnt_d   = '0;
            tail_d  = 1'b0;
            cause_d = CS_STOPREC;
        end
    end

    // Outputs
    always_comb begin
        chip_rst = (state_q != SQ_RUN);
        cause    = cause_q;
    end
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
    parameter int unsigned WDT_LIMIT  = 130416,
    parameter int unsigned POR_TICKS  = 16362,
    parameter int unsigned EXTRA_CLKS = 18,
    parameter logic [15:0] RST_VECTOR = 16'h000C
) (
    input  logic        clk,
    input  logic        pwr_good,
    input  logic        rc_tick,
    input  logic        opt_perm,
    input  logic        opt_sysclk_src,
    input  logic        stop_rec_req,
    input  logic        wdt_cmd,
    input  logic        wdh_cmd,
    input  logic        halt_mode,
    input  logic        stop_mode,
    output logic        chip_rst,
    output logic [2:0]  rst_cause,
    output logic [15:0] rst_vector
);
    import rstseq_pkg::*;

    localparam int unsigned WD_CW = $clog2(WDT_LIMIT + 1);

    logic             tick;
    logic             wd_expire;
    logic             wd_halt_run;
    logic [WD_CW-1:0] wd_cnt;
    cause_t           cause_w;

    rstseq_tick_sel u_tick (
        .sysclk_src (opt_sysclk_src),
        .rc_tick    (rc_tick),
        .tick       (tick)
    );

    rstseq_wdog #(.LIMIT(WDT_LIMIT)) u_wdog (
        .clk            (clk),
        .arst_n         (pwr_good),
        .tick           (tick),
        .rst_hold       (chip_rst),
        .wdt_cmd        (wdt_cmd),
        .wdh_cmd        (wdh_cmd),
        .halt_mode      (halt_mode),
        .stop_mode      (stop_mode),
        .opt_perm       (opt_perm),
        .opt_sysclk_src (opt_sysclk_src),
        .expire         (wd_expire),
        .halt_run       (wd_halt_run),
        .cnt_q          (wd_cnt)
    );

    rstseq_seq #(.POR_TICKS(POR_TICKS), .EXTRA_CLKS(EXTRA_CLKS)) u_seq (
        .clk       (clk),
        .arst_n    (pwr_good),
        .tick      (tick),
        .stop_req  (stop_rec_req),
        .wd_expire (wd_expire),
        .halt_mode (halt_mode),
        .stop_mode (stop_mode),
        .chip_rst  (chip_rst),
        .cause     (cause_w)
    );

    assign rst_cause  = cause_w;
    assign rst_vector = RST_VECTOR;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
    parameter int unsigned LIMIT = 130416,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input logic          clk,
    input logic          pwr_good,
    input logic          opt_perm,
    input logic          opt_sysclk_src,
    input logic          stop_rec_req,
    input logic          wdt_cmd,
    input logic          halt_mode,
    input logic          stop_mode,
    input logic          chip_rst,
    input logic [2:0]    rst_cause,
    input logic          wd_halt_run,
    input logic [CW-1:0] wd_cnt
);
    AST_STOPREC_HOLDS: assert property (@(posedge clk) disable iff (!pwr_good)
        stop_rec_req |=> chip_rst); // R10

    AST_CAUSE_ONLY_IN_RST: assert property (@(posedge clk) disable iff (!pwr_good)
        !$stable(rst_cause) |-> chip_rst); // R12

    AST_STOP_NO_EXPIRY: assert property (@(posedge clk) disable iff (!pwr_good)
        (stop_mode && !(opt_perm && !opt_sysclk_src) && !stop_rec_req && !chip_rst) |=> !chip_rst); // R8

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!pwr_good)
        (halt_mode && !stop_mode && !wd_halt_run && !wdt_cmd && !chip_rst) |=> $stable(wd_cnt)); // R7

    AST_REFRESH_CLEARS: assert property (@(posedge clk) disable iff (!pwr_good)
        (!chip_rst && wdt_cmd) |=> (wd_cnt == '0)); // R5
endmodule

bind rstseq_top rstseq_chk #(.LIMIT(WDT_LIMIT)) u_chk (
    .clk            (clk),
    .pwr_good       (pwr_good),
    .opt_perm       (opt_perm),
    .opt_sysclk_src (opt_sysclk_src),
    .stop_rec_req   (stop_rec_req),
    .wdt_cmd        (wdt_cmd),
    .halt_mode      (halt_mode),
    .stop_mode      (stop_mode),
    .chip_rst       (chip_rst),
    .rst_cause      (rst_cause),
    .wd_halt_run    (wd_halt_run),
    .wd_cnt         (wd_cnt)
);

// File: tb/sim_rstseq_top.sv
module sim_rstseq_top;
    localparam int T = 40;
    localparam int P = 12;
    localparam int E = 3;

    logic        clk = 1'b0;
    logic        pwr_good = 1'b0;
    logic        rc_tick = 1'b0;
    logic        opt_perm = 1'b0;
    logic        opt_sysclk_src = 1'b1;
    logic        stop_rec_req = 1'b0;
    logic        wdt_cmd = 1'b0;
    logic        wdh_cmd = 1'b0;
    logic        halt_mode = 1'b0;
    logic        stop_mode = 1'b0;
    logic        chip_rst;
    logic [2:0]  rst_cause;
    logic [15:0] rst_vector;

    int compared = 0;
    int mismatched = 0;

    rstseq_top #(.WDT_LIMIT(T), .POR_TICKS(P), .EXTRA_CLKS(E)) u0 (
        .clk(clk), .pwr_good(pwr_good), .rc_tick(rc_tick), .opt_perm(opt_perm),
        .opt_sysclk_src(opt_sysclk_src), .stop_rec_req(stop_rec_req),
        .wdt_cmd(wdt_cmd), .wdh_cmd(wdh_cmd), .halt_mode(halt_mode),
        .stop_mode(stop_mode), .chip_rst(chip_rst), .rst_cause(rst_cause),
        .rst_vector(rst_vector)
    );

    always #10 clk = ~clk;

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_wdt();
        wdt_cmd = 1'b1; step(1); wdt_cmd = 1'b0;
    endtask

    task automatic pulse_wdh();
        wdh_cmd = 1'b1; step(1); wdh_cmd = 1'b0;
    endtask

    task automatic power_cycle(input logic perm, input logic src);
        pwr_good = 1'b0;
        opt_perm = perm;
        opt_sysclk_src = src;
        step(2);
        chk("R1 reset held while power bad", {31'd0, chip_rst}, 1);
        chk("R1 cause power", {29'd0, rst_cause}, 1);
        pwr_good = 1'b1;
    endtask

    task automatic t_power_on();
        power_cycle(1'b0, 1'b1);
        chk("R2 vector", {16'd0, rst_vector}, 32'h000C);
        step(P - 1);
        chk("R1 still held before count end", {31'd0, chip_rst}, 1);
        step(1);
        chk("R1 released after POR_TICKS", {31'd0, chip_rst}, 0);
    endtask

    task automatic t_cmd_in_reset();
        power_cycle(1'b0, 1'b1);
        step(3);
        pulse_wdt();
        step(P - 4);
        chk("R1 release after power cycle", {31'd0, chip_rst}, 0);
        step(2 * T);
        chk("R3 command during reset ignored", {31'd0, chip_rst}, 0);
    endtask

    task automatic t_arm_timeout();
        pulse_wdt();
        step(T - 1);
        chk("R4 no expiry before limit", {31'd0, chip_rst}, 0);
        step(1);
        chk("R4 expiry at limit", {31'd0, chip_rst}, 1);
        chk("R4 cause run", {29'd0, rst_cause}, 3);
        step(P + E - 1);
        chk("R6 held through clock tail", {31'd0, chip_rst}, 1);
        step(1);
        chk("R6 released after tail", {31'd0, chip_rst}, 0);
        step(2 * T);
        chk("R3 disarmed after watchdog reset", {31'd0, chip_rst}, 0);
    endtask

    task automatic t_refresh();
        pulse_wdt();
        step(T - 5);
        pulse_wdt();
        step(T - 1);
        chk("R5 refresh restarted count", {31'd0, chip_rst}, 0);
        step(1);
        chk("R5 expiry after refresh", {31'd0, chip_rst}, 1);
        step(P + E);
        chk("R6 release", {31'd0, chip_rst}, 0);
    endtask

    task automatic t_halt_frozen();
        pulse_wdt();
        step(10);
        halt_mode = 1'b1;
        step(100);
        chk("R7 halt freezes count", {31'd0, chip_rst}, 0);
        halt_mode = 1'b0;
        step(T - 11);
        chk("R7 count kept across halt", {31'd0, chip_rst}, 0);
        step(1);
        chk("R7 expiry after resume", {31'd0, chip_rst}, 1);
        chk("R4 cause run after halt", {29'd0, rst_cause}, 3);
        step(P + E);
    endtask

    task automatic t_halt_enable();
        pulse_wdt();
        step(10);
        pulse_wdh();
        halt_mode = 1'b1;
        step(T - 12);
        chk("R7 halt-enable keeps count", {31'd0, chip_rst}, 0);
        step(1);
        chk("R7 expiry in halt", {31'd0, chip_rst}, 1);
        chk("R4 cause halt", {29'd0, rst_cause}, 4);
        step(P + E);
        halt_mode = 1'b0;
        chk("R6 release after halt expiry", {31'd0, chip_rst}, 0);
    endtask

    task automatic t_wdh_before_arm();
        pulse_wdh();
        pulse_wdt();
        halt_mode = 1'b1;
        step(2 * T);
        chk("R7 early halt-enable has no effect", {31'd0, chip_rst}, 0);
        halt_mode = 1'b0;
    endtask

    task automatic t_stop_and_recovery();
        stop_mode = 1'b1;
        step(2 * T);
        chk("R8 no expiry in stop", {31'd0, chip_rst}, 0);
        stop_rec_req = 1'b1;
        step(1);
        chk("R10 recovery asserts reset", {31'd0, chip_rst}, 1);
        chk("R10 cause stop recovery", {29'd0, rst_cause}, 2);
        step(3);
        stop_rec_req = 1'b0;
        stop_mode = 1'b0;
        step(P - 1);
        chk("R10 hold restarted by level", {31'd0, chip_rst}, 1);
        step(1);
        chk("R10 release without tail", {31'd0, chip_rst}, 0);
    endtask

    task automatic t_perm_sysclk();
        power_cycle(1'b1, 1'b1);
        step(T - 1);
        chk("R9 permanent counts from power-up", {31'd0, chip_rst}, 0);
        step(1);
        chk("R9 permanent expiry", {31'd0, chip_rst}, 1);
        chk("R9 cause run", {29'd0, rst_cause}, 3);
        step(P + E);
        stop_mode = 1'b1;
        step(2 * T);
        chk("R9 system-clock source stops in stop", {31'd0, chip_rst}, 0);
        stop_mode = 1'b0;
    endtask

    task automatic t_perm_rc_stop();
        rc_tick = 1'b0;
        stop_mode = 1'b1;
        power_cycle(1'b1, 1'b0);
        step(50);
        chk("R11 no ticks keeps reset held", {31'd0, chip_rst}, 1);
        rc_tick = 1'b1;
        step(P - 1);
        chk("R11 hold counts ticks", {31'd0, chip_rst}, 1);
        step(1);
        chk("R11 release after ticks", {31'd0, chip_rst}, 0);
        step(T - P - 1);
        chk("R9 slow source before expiry", {31'd0, chip_rst}, 0);
        step(1);
        chk("R9 runs in stop with slow source", {31'd0, chip_rst}, 1);
        chk("R4 cause stop", {29'd0, rst_cause}, 5);
        stop_mode = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        #(200000 * 20);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        t_power_on();
        t_cmd_in_reset();
        t_arm_timeout();
        t_refresh();
        t_halt_frozen();
        t_halt_enable();
        t_wdh_before_arm();
        t_stop_and_recovery();
        t_perm_sysclk();
        t_perm_rc_stop();
        summary();
        $finish;
    end
endmodule